// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Automatic Flow Control

This block is the receive half of an asynchronous serial port. An external baud divider supplies a one-cycle sample enable at sixteen times the bit rate. On each enable the block samples a synchronised copy of the serial line. It qualifies a falling edge as a start bit only if the line is still low near the middle of that bit. It then gathers 5 to 8 data bits, least significant first, optionally followed by a parity bit and a single stop bit.

Every completed character is written into a 16-entry queue, together with three flags: parity error, framing error and line break. The CPU side sees the oldest entry all the time and removes it with a one-cycle pop strobe. A ready output shows that at least one entry is waiting.

When automatic flow control is switched on, the request-to-send output drops once the queue occupancy reaches a selected threshold. It rises again as soon as the queue drains below that threshold. This lets the far end stop sending before the queue can overflow. A character that completes while the queue is full is dropped, and a one-cycle overrun pulse reports it.

Top module: `uart_rx_flow`

## Requirements
- R1: A low line seen on a sample enable while idle is confirmed as a start bit only if the line is still low on the 7th following enable. Each later bit is sampled exactly 16 enables after the previous one, and data bits arrive least significant bit first.
- R2: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. In stored data, the bit positions above the character length read 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 means even parity and 1 means odd parity. The stored parity-error flag is 1 exactly when the data bits plus the parity bit have the wrong sense. With `cfg_par_en`=0 the flag is always 0.
- R4: If the line is high again when the start bit is confirmed, this is a false start. The receiver returns to idle, nothing is stored and `fifo_count` does not change.
- R5: The framing-error flag is 1 when the stop bit samples low. After such a character the receiver looks for no new start bit until the line has returned high.
- R6: The break flag is 1 when every data bit, the parity bit (if enabled) and the stop bit all sampled low.
- R7: The queue holds up to 16 characters in arrival order. `rd_data`/`rd_perr`/`rd_ferr`/`rd_brk` show the oldest entry. `fifo_count` gives the occupancy, and `rx_ready` is 1 exactly when the occupancy is non-zero.
- R8: A character that completes while `fifo_count` is 16 is discarded and `overrun` pulses high for one cycle. The queue contents and occupancy are left unchanged by the dropped character.
- R9: A `pop` while the queue is empty has no effect, and `fifo_count` stays 0.
- R10: With `cfg_auto_rts`=1, `rts` is 0 whenever `fifo_count` is at least the level chosen by `cfg_trig`, and 1 otherwise. The levels are 0 for 1, 1 for 4, 2 for 8 and 3 for 14. With `cfg_auto_rts`=0, `rts` is always 1.
- R11: After reset the queue is empty, `rx_ready` and `overrun` are 0, and `rts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length select (5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_auto_rts | input | 1 | Enable automatic request-to-send |
| cfg_trig | input | 2 | Flow-control threshold select |
| pop | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity-error flag of the oldest entry |
| rd_ferr | output | 1 | Framing-error flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| rx_ready | output | 1 | Queue is not empty |
| fifo_count | output | 5 | Queue occupancy, 0..16 |
| overrun | output | 1 | One-cycle pulse when a character is dropped |
| rts | output | 1 | Request to send, 1 = far end may send |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that did not re-check the start bit at mid-bit would store a spurious character, which shows up as a wrong `fifo_count`. Short characters are sent with even and with odd parity, and some have a deliberately wrong parity bit. Mis-aligned bit assembly or a parity sense that is the wrong way round would give stored data with stray high bits or a wrong flag. A framing error and a long break are followed by a return to the idle level. A receiver that did not wait for the line to go high would store extra break characters. The queue is filled past 16 with the threshold changing as it fills. Every clock, `rts` is compared against the occupancy, so a threshold that is off by one, or a 17th character that overwrites an entry instead of being dropped, fails a check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_MARK
    } rx_state_e;

    // Index of the last data bit for a length select (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len_sel);
        return 3'd4 + {1'b0, len_sel};
    endfunction

    // Flow-control threshold for a level select
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       push,
    output rx_char_t   push_char
);
    localparam int PW  = $clog2(OSR);
    localparam int MID = OSR / 2 - 1;

    rx_state_e     state;
    logic [PW-1:0] phase;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          par_acc;
    logic          all_low;
    logic          bit_due;

    assign bit_due = (phase == PW'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            all_low   <= 1'b1;
            push      <= 1'b0;
            push_char <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !line) begin
                        state <= ST_START;
                        phase <= PW'(1);
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (phase == PW'(MID)) begin
                            if (!line) begin
                                state   <= ST_DATA;
                                phase   <= '0;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_acc <= 1'b0;
                                all_low <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (bit_due) begin
                            shreg[bit_idx] <= line;
                            par_acc        <= par_acc ^ line;
                            all_low        <= all_low & ~line;
                            phase          <= '0;
                            if (bit_idx == last_bit_idx(cfg_len)) begin
                                state <= cfg_par_en ? ST_PARITY : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (tick) begin
                        if (bit_due) begin
                            par_acc <= par_acc ^ line;
                            all_low <= all_low & ~line;
                            phase   <= '0;
                            state   <= ST_STOP;
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (bit_due) begin
                            push           <= 1'b1;
                            push_char.data <= shreg;
                            push_char.perr <= cfg_par_en & (par_acc ^ cfg_par_odd);
                            push_char.ferr <= ~line;
                            push_char.brk  <= all_low & ~line;
                            phase          <= '0;
                            state          <= line ? ST_IDLE : ST_WAIT_MARK;
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                end
                ST_WAIT_MARK: begin
                    if (line) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  rx_char_t      wr_char,
    input  logic          rd,
    output rx_char_t      head,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_wr;
    logic          do_rd;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && (count != '0);
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= next_ptr(wptr);
            if (do_rd) rptr <= next_ptr(rptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
    import uart_rx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] count,
    input  logic          auto_en,
    input  logic [1:0]    trig_sel,
    output logic          rts
);
    logic at_level;

    assign at_level = (32'(count) >= 32'(trig_level(trig_sel)));
    assign rts      = !(auto_en && at_level);
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_auto_rts,
    input  logic [1:0]    cfg_trig,
    input  logic          pop,
    output logic [7:0]    rd_data,
    output logic          rd_perr,
    output logic          rd_ferr,
    output logic          rd_brk,
    output logic          rx_ready,
    output logic [CW-1:0] fifo_count,
    output logic          overrun,
    output logic          rts
);
    logic     line_s;
    logic     push;
    rx_char_t push_char;
    rx_char_t head;
    logic     full;

    rx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    rx_bit_engine #(.OSR(OSR)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .line        (line_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push        (push),
        .push_char   (push_char)
    );

    rx_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr      (push),
        .wr_char (push_char),
        .rd      (pop),
        .head    (head),
        .count   (fifo_count),
        .full    (full)
    );

    rx_flow_ctl #(.CW(CW)) u_flow (
        .count    (fifo_count),
        .auto_en  (cfg_auto_rts),
        .trig_sel (cfg_trig),
        .rts      (rts)
    );

    always_ff @(posedge clk) begin
        if (rst) overrun <= 1'b0;
        else     overrun <= push && full;
    end

    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;
    assign rd_brk   = head.brk;
    assign rx_ready = (fifo_count != '0);
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          pop,
    input logic          cfg_auto_rts,
    input logic [CW-1:0] fifo_count,
    input logic          overrun,
    input logic          rts
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_count) <= DEPTH); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == $past(fifo_count)) ||
        (fifo_count == $past(fifo_count) + CW'(1)) ||
        (fifo_count == $past(fifo_count) - CW'(1))); // R7

    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (32'($past(fifo_count)) == DEPTH)); // R8

    AST_OVR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (overrun && !$past(pop)) |-> (fifo_count == $past(fifo_count))); // R8

    AST_RTS_DOWN_FULL: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto_rts && 32'(fifo_count) == DEPTH) |-> !rts); // R10

    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !cfg_auto_rts |-> rts); // R10
endmodule

bind uart_rx_flow uart_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pop          (pop),
    .cfg_auto_rts (cfg_auto_rts),
    .fifo_count   (fifo_count),
    .overrun      (overrun),
    .rts          (rts)
);

// File: tb/tb_uart_rx_flow.sv
`timescale 1ns/1ps
module tb_uart_rx_flow;
    localparam int BITCLK = 64;   // 16 enables x 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_auto_rts = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, rx_ready, overrun, rts;
    logic [4:0] fifo_count;

    int n_cmp = 0;
    int n_bad = 0;
    int ovr_seen = 0;
    int ovr_exp = 0;
    bit running = 1'b0;
    logic [10:0] q [$];

    uart_rx_flow dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_auto_rts(cfg_auto_rts), .cfg_trig(cfg_trig), .pop(pop),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rx_ready(rx_ready), .fifo_count(fifo_count), .overrun(overrun), .rts(rts)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_trig(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // every-clock comparison of ready and flow-control outputs
    always @(negedge clk) begin
        if (running) begin
            int exp_rts;
            exp_rts = (cfg_auto_rts && int'(fifo_count) >= model_trig(cfg_trig)) ? 0 : 1;
            check(rts == exp_rts[0], "R10 rts", rts, exp_rts);
            check(rx_ready == (fifo_count != 0), "R7 rx_ready", rx_ready, fifo_count != 0);
            if (overrun) ovr_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        rxd = v;
        idle(BITCLK);
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input logic stop_v);
        int nb;
        logic [7:0] m;
        logic p;
        logic perr, ferr, brk;
        nb = 5 + int'(cfg_len);
        m = d & ((8'd1 << nb) - 8'd1);
        p = (^m) ^ cfg_par_odd ^ bad_par;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(m[i]);
        if (cfg_par_en) send_bit(p);
        send_bit(stop_v);
        rxd = 1'b1;
        idle(32);
        perr = cfg_par_en && bad_par;
        ferr = !stop_v;
        brk  = (m == 0) && (!cfg_par_en || !p) && !stop_v;
        if (q.size() == 16) ovr_exp++;
        else q.push_back({m, perr, ferr, brk});
    endtask

    task automatic pop_check(input string req);
        logic [10:0] e;
        logic [10:0] a;
        e = q.pop_front();
        a = {rd_data, rd_perr, rd_ferr, rd_brk};
        check(a == e, req, a, e);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_check(input string req);
        check(int'(fifo_count) == q.size(), req, fifo_count, q.size());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(fifo_count == 0, "R11 count", fifo_count, 0);
        check(rx_ready == 0, "R11 ready", rx_ready, 0);
        check(overrun == 0, "R11 overrun", overrun, 0);
        check(rts == 1, "R11 rts", rts, 1);
        running = 1'b1;

        // R1 R2: 8-bit, no parity
        send_char(8'hA5, 0, 1);
        send_char(8'h3C, 0, 1);
        count_check("R7 count two");
        pop_check("R1 first char");
        pop_check("R1 second char");

        // R9 pop on empty
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
        check(fifo_count == 0, "R9 empty pop", fifo_count, 0);

        // R2 R3: short characters with parity
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_char(8'hFF, 0, 1);
        send_char(8'h13, 1, 1);
        cfg_len = 2'd1; cfg_par_odd = 1'b1;
        send_char(8'hEA, 0, 1);
        send_char(8'h2D, 1, 1);
        cfg_len = 2'd2;
        send_char(8'hD5, 0, 1);
        count_check("R7 count five");
        pop_check("R2 5-bit even");
        pop_check("R3 5-bit even bad parity");
        pop_check("R2 6-bit odd");
        pop_check("R3 6-bit odd bad parity");
        pop_check("R2 7-bit odd");

        // R5 framing error then resume
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        send_char(8'h81, 0, 0);
        send_char(8'h5A, 0, 1);
        count_check("R5 count after framing");
        pop_check("R5 framing flag");
        pop_check("R5 resumed char");

        // R6 long break: one entry only
        rxd = 1'b0;
        idle(BITCLK * 14);
        rxd = 1'b1;
        idle(BITCLK * 2);
        q.push_back({8'h00, 1'b0, 1'b1, 1'b1});
        count_check("R6 single break entry");
        pop_check("R6 break flags");

        // R6 with odd parity: parity low gives parity error too
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        send_char(8'h00, 1, 0);
        pop_check("R6 break odd parity");
        cfg_par_en = 1'b0;

        // R4 false start glitch
        rxd = 1'b0;
        idle(8);
        rxd = 1'b1;
        idle(BITCLK * 12);
        count_check("R4 false start");

        // R8 R10: fill with flow control, thresholds varied
        cfg_auto_rts = 1'b1; cfg_trig = 2'd1;
        for (int i = 0; i < 16; i++) begin
            if (i == 5) cfg_trig = 2'd2;
            if (i == 10) cfg_trig = 2'd3;
            if (i == 13) cfg_trig = 2'd0;
            send_char(8'(i * 17 + 3), 0, 1);
        end
        count_check("R7 count full");
        cfg_trig = 2'd3;
        send_char(8'hEE, 0, 1);
        count_check("R8 count after overrun");
        check(ovr_seen == ovr_exp, "R8 overrun pulses", ovr_seen, ovr_exp);
        for (int i = 0; i < 16; i++) begin
            if (i == 8) cfg_trig = 2'd2;
            pop_check("R8 contents kept");
        end
        count_check("R7 drained");
        cfg_auto_rts = 1'b0;
        send_char(8'h77, 0, 1);
        pop_check("R10 manual mode char");

        running = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule